// File: doc/BRIEF.md
# 64-bit Register-Programmed Event Timer

This block is a system-tick event source built around a 64-bit up-counter and a 64-bit period value. Software reaches both through pairs of 32-bit words on a plain word-wide register bus (address, write enable, write data and combinational read data). When the running count equals the period, a terminal event fires. In periodic operation the count wraps to zero and keeps going. In one-shot operation the count freezes and the timer disarms itself.

Counting is gated twice. A two-bit mode field in the control word must select one-shot or periodic operation. A two-bit release field in the global word must also be fully set. Clearing either one stops the counter on the very next clock edge, so software can rewrite the count and period safely before it re-arms the timer. A terminal event sets a sticky flag. The flag drives the interrupt output through an enable bit, and software clears it by writing one to it.

Top module: `tick_timer64`

## Requirements
- R1: After the asynchronous active-low reset, every register reads zero and `irq_o` is low.
- R2: Word registers sit at these byte addresses: count low 0x10, count high 0x14, period low 0x18, period high 0x1C, control 0x20, global 0x24, interrupt 0x44. A write lands at the clock edge where `we_i` is high. `rdata_o` follows `addr_i` without a clock.
- R3: The mode field is control bits [7:6], where 00 means off, 01 one-shot, 10 periodic and 11 is treated as off. While the mode is 01 or 10 and the release field is 3, the count rises by one on each clock. Any other mode holds the count from the first edge after the mode write has landed.
- R4: The release field is global bits [1:0]. Any value other than 3 holds the count unchanged.
- R5: Both count words and both period words can be written directly, and the period words read back as written. A count write takes precedence over counting in the same cycle.
- R6: In periodic mode, an edge where the 64-bit count equals the 64-bit period loads zero into the count. The next terminal event follows period+1 clocks later.
- R7: In one-shot mode, the equality edge leaves the count at the period value, and the mode field reads 00 from then on.
- R8: A terminal event sets the sticky flag at interrupt bit 1. Writing 1 to bit 1 clears the flag, but a terminal event in the same cycle wins.
- R9: `irq_o` is high exactly while the flag and the enable (interrupt bit 0) are both set. With the enable clear, the flag still records events.
- R10: Bits outside the defined fields read as zero, and unmapped addresses read zero.
- R11: The low count word carries into the high word, and the terminal compare covers all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the word being accessed |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt, flag AND enable |

## Verification
The hardest cases to reach are the ones where a terminal event lands on the same edge as a bus action. One is a flag clear colliding with a new event. Another is the 64-bit compare matching only after a carry into the high word. For the collision, the bench programs a period of zero in periodic mode, so a terminal event occurs on every edge, and then writes the clear. For the carry, it preloads the low count word to two below its wrap point and sets a period whose only nonzero bit is in the high word. Every count expectation comes from counting clock edges from the edge where the arming write landed.

// File: rtl/tick_timer64_pkg.sv
package tick_timer64_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_LOOP = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PER_LO = 8'h18;
  localparam logic [7:0] OFS_PER_HI = 8'h1C;
  localparam logic [7:0] OFS_CTRL   = 8'h20;
  localparam logic [7:0] OFS_GLOB   = 8'h24;
  localparam logic [7:0] OFS_INTR   = 8'h44;

  localparam logic [1:0] RELEASE_ALL = 2'b11;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic per_lo;
    logic per_hi;
    logic ctrl;
    logic glob;
    logic intr;
  } wstb_t;
endpackage

// File: rtl/tick_timer64_dec.sv
module tick_timer64_dec
  import tick_timer64_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  output wstb_t         stb_o
);
  always_comb begin
    stb_o        = '0;
    stb_o.cnt_lo = we_i && (addr_i == AW'(OFS_CNT_LO));
    stb_o.cnt_hi = we_i && (addr_i == AW'(OFS_CNT_HI));
    stb_o.per_lo = we_i && (addr_i == AW'(OFS_PER_LO));
    stb_o.per_hi = we_i && (addr_i == AW'(OFS_PER_HI));
    stb_o.ctrl   = we_i && (addr_i == AW'(OFS_CTRL));
    stb_o.glob   = we_i && (addr_i == AW'(OFS_GLOB));
    stb_o.intr   = we_i && (addr_i == AW'(OFS_INTR));
  end
endmodule

// File: rtl/tick_timer64_ctl.sv
module tick_timer64_ctl
  import tick_timer64_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wstb_t      stb_i,
  input  logic [1:0] mode_wd_i,
  input  logic [1:0] low_wd_i,
  input  logic       hit_i,
  output mode_e      mode_o,
  output logic [1:0] glob_o,
  output logic       irq_en_o,
  output logic       irq_flag_o,
  output logic       run_o,
  output logic       loop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_OFF;
      glob_o     <= '0;
      irq_en_o   <= 1'b0;
      irq_flag_o <= 1'b0;
    end else begin
      if (stb_i.ctrl)                          mode_o <= mode_e'(mode_wd_i);
      else if (hit_i && mode_o == MODE_ONCE)   mode_o <= MODE_OFF;
      if (stb_i.glob) glob_o <= low_wd_i;
      if (stb_i.intr) irq_en_o <= low_wd_i[0];
      // a new event beats a clear in the same cycle
      if (hit_i)                          irq_flag_o <= 1'b1;
      else if (stb_i.intr && low_wd_i[1]) irq_flag_o <= 1'b0;
    end
  end

  assign run_o  = (mode_o == MODE_ONCE || mode_o == MODE_LOOP) && (glob_o == RELEASE_ALL);
  assign loop_o = (mode_o == MODE_LOOP);

  assert_once_disarm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && mode_o == MODE_ONCE && !stb_i.ctrl |=> mode_o == MODE_OFF);
  assert_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> irq_flag_o);
  assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_o && !stb_i.intr |=> irq_flag_o);
endmodule

// File: rtl/tick_timer64_cnt.sv
module tick_timer64_cnt
  import tick_timer64_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wstb_t         stb_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          run_i,
  input  logic          loop_i,
  output logic [2*DW-1:0] cnt_o,
  output logic [2*DW-1:0] per_o,
  output logic          hit_o
);
  localparam int unsigned CW = 2 * DW;

  logic cnt_wr;
  assign cnt_wr = stb_i.cnt_lo | stb_i.cnt_hi;
  assign hit_o  = run_i && (cnt_o == per_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      per_o <= '0;
    end else begin
      if (stb_i.per_lo) per_o[DW-1:0]  <= wdata_i;
      if (stb_i.per_hi) per_o[CW-1:DW] <= wdata_i;
      if (cnt_wr) begin
        if (stb_i.cnt_lo) cnt_o[DW-1:0]  <= wdata_i;
        if (stb_i.cnt_hi) cnt_o[CW-1:DW] <= wdata_i;
      end else if (hit_o) begin
        if (loop_i) cnt_o <= '0;
      end else if (run_i) begin
        cnt_o <= cnt_o + CW'(1);
      end
    end
  end

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !hit_o && !cnt_wr |=> cnt_o == $past(cnt_o) + CW'(1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !cnt_wr |=> $stable(cnt_o));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && loop_i && !cnt_wr |=> cnt_o == '0);
  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !loop_i && !cnt_wr |=> $stable(cnt_o));
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tick_timer64_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int unsigned CW = 2 * DW;

  wstb_t         stb;
  mode_e         mode;
  logic [1:0]    glob;
  logic          irq_en, irq_flag, run, loop_m, hit;
  logic [CW-1:0] cnt, per;

  tick_timer64_dec #(.AW(AW)) i_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .stb_o  (stb)
  );

  tick_timer64_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb),
    .mode_wd_i  (wdata_i[7:6]),
    .low_wd_i   (wdata_i[1:0]),
    .hit_i      (hit),
    .mode_o     (mode),
    .glob_o     (glob),
    .irq_en_o   (irq_en),
    .irq_flag_o (irq_flag),
    .run_o      (run),
    .loop_o     (loop_m)
  );

  tick_timer64_cnt #(.DW(DW)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (stb),
    .wdata_i (wdata_i),
    .run_i   (run),
    .loop_i  (loop_m),
    .cnt_o   (cnt),
    .per_o   (per),
    .hit_o   (hit)
  );

  always_comb begin
    rdata_o = '0;
    if      (addr_i == AW'(OFS_CNT_LO)) rdata_o = cnt[DW-1:0];
    else if (addr_i == AW'(OFS_CNT_HI)) rdata_o = cnt[CW-1:DW];
    else if (addr_i == AW'(OFS_PER_LO)) rdata_o = per[DW-1:0];
    else if (addr_i == AW'(OFS_PER_HI)) rdata_o = per[CW-1:DW];
    else if (addr_i == AW'(OFS_CTRL))   rdata_o[7:6] = mode;
    else if (addr_i == AW'(OFS_GLOB))   rdata_o[1:0] = glob;
    else if (addr_i == AW'(OFS_INTR))   rdata_o[1:0] = {irq_flag, irq_en};
  end

  assign irq_o = irq_flag & irq_en;

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en && !(stb.intr && wdata_i[0]) |=> !irq_o);
endmodule

// File: tb/test_tick_timer64.sv
`timescale 1ns/100ps
module test_tick_timer64;
  localparam real CLK_PERIOD = 10.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  go;

  tick_timer64 i_tick_timer64 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD / 2.0) clk_i = ~clk_i;

  // monitor: pops expected items and compares them with the outputs
  initial forever begin
    item_t it;
    logic [31:0] act;
    @(go);
    #0.2;
    it = sb_q.pop_front();
    act = it.is_irq ? {31'd0, irq_o} : rdata_o;
    n_checks++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    addr_i = a;
    ->go;
    #0.4;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    ->go;
    #0.4;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(1);
    // R1 reset state
    chk(8'h10, 0, "R1 cnt_lo"); chk(8'h14, 0, "R1 cnt_hi"); chk(8'h1C, 0, "R1 per_hi");
    wait_cyc(1);
    chk(8'h20, 0, "R1 ctrl"); chk(8'h24, 0, "R1 glob"); chk(8'h44, 0, "R1 intr");
    chk_irq(0, "R1 irq");

    // R2/R5 programming and readback
    wr(8'h24, 32'h3);
    wr(8'h18, 32'd9);
    chk(8'h18, 9, "R5 per_lo readback"); chk(8'h24, 3, "R2 glob readback");
    wr(8'h80 >> 0 == 0 ? 8'h20 : 8'h20, 32'h80);   // periodic, lands at E0
    wait_cyc(3);
    chk(8'h10, 3, "R3 count step"); chk(8'h44, 0, "R8 flag idle");
    wait_cyc(7);
    chk(8'h10, 0, "R6 periodic wrap"); chk(8'h44, 2, "R8 flag set");
    chk_irq(0, "R9 masked");
    wr(8'h44, 32'h1);                                // E11
    chk_irq(1, "R9 irq asserted");
    wr(8'h44, 32'h3);                                // E12 clear
    chk(8'h44, 1, "R8 flag cleared"); chk_irq(0, "R9 irq after clear");
    wait_cyc(8);                                     // E20
    chk(8'h10, 0, "R6 second wrap"); chk_irq(1, "R6 second event");

    // R4 release gating
    wr(8'h24, 32'h1);                                // E21: counts 0->1
    wait_cyc(5);
    chk(8'h10, 1, "R4 held");
    wr(8'h24, 32'h3);                                // E27 no count
    wait_cyc(2);
    chk(8'h10, 3, "R4 resumed");

    // R3 mode off and reserved
    wr(8'h20, 32'h0);                                // E30: 3->4
    wait_cyc(3);
    chk(8'h10, 4, "R3 stopped"); chk(8'h20, 0, "R3 ctrl off");
    wr(8'h20, 32'hC0);
    wait_cyc(2);
    chk(8'h10, 4, "R3 reserved mode holds"); chk(8'h20, 32'hC0, "R3 ctrl rsvd");
    wr(8'h20, 32'h0);

    // R7 one-shot
    wr(8'h44, 32'h3);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'd4);
    wr(8'h20, 32'h40);                               // Ea
    wait_cyc(5);                                     // Ea+5 hit
    chk(8'h10, 4, "R7 frozen at period"); chk(8'h20, 0, "R7 disarmed");
    wait_cyc(1);
    chk(8'h44, 3, "R8 one-shot flag"); chk_irq(1, "R9 one-shot irq");
    wait_cyc(3);
    chk(8'h10, 4, "R7 stays frozen");

    // R11 64-bit carry and compare
    wr(8'h44, 32'h3);
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h14, 32'h0);
    wr(8'h20, 32'h80);                               // Eb
    wait_cyc(2);
    chk(8'h10, 0, "R11 low wrapped"); chk(8'h14, 1, "R11 carry into high");
    chk(8'h44, 1, "R11 no early event");
    wait_cyc(1);
    chk(8'h14, 0, "R11 64-bit match wrap"); chk(8'h44, 3, "R11 event flag");
    wr(8'h10, 32'd5);
    chk(8'h10, 5, "R5 write over counting");
    wait_cyc(2);
    chk(8'h10, 7, "R5 counting resumes"); chk(8'h1C, 1, "R5 per_hi readback");

    // R8 set beats clear: period 0 gives an event every edge
    wr(8'h20, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h10, 32'h0);
    wr(8'h20, 32'h80);
    wr(8'h44, 32'h3);
    chk(8'h44, 3, "R8 set wins over clear"); chk(8'h10, 0, "R6 zero period");

    // R10 unused bits and unmapped words
    wr(8'h20, 32'hFFFF_FF3F);
    chk(8'h20, 0, "R10 ctrl unused bits");
    wr(8'h24, 32'hFFFF_FFFF);
    chk(8'h24, 3, "R10 glob unused bits");
    chk(8'h00, 0, "R10 unmapped 0x00"); chk(8'h28, 0, "R10 unmapped 0x28");

    finished = 1'b1;
    wait_cyc(1);
    summary();
  end
endmodule